// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad of 32-bit words spread over a set of interleaved banks. A group of lanes presents one request at a time. Each lane carries its own enable, read/write flag, word address and write data, and each bank can perform one word access per clock cycle. The block maps every lane to a bank. It finds the lanes that compete for different words of the same bank and replays the request over as many passes as the most contested bank needs. Lanes that name the very same word are folded into one access.

A client raises `req_valid` with the lane vectors while `busy` is low. `busy` then stays high for one cycle per pass. When the last pass is done, `done` pulses for one cycle and the per-lane read data is presented. The read data stays put until the next request is taken. A unit-stride pattern costs a single pass. A pattern in which every lane hits one bank at different words costs one pass per lane.

Top module: `banked_scratchpad`

## Requirements
- R1: A word address selects bank `addr % 32` (its low 5 bits) and row `addr / 32` (its upper bits). A value written to an address is returned by a later read of that same address.
- R2: A request whose active lanes all fall in distinct banks completes in one pass: `busy` is high for exactly one cycle, and `done` rises in the following cycle.
- R3: The number of passes, which is the number of cycles `busy` is high, equals the largest count of distinct words requested within any one bank. A stride-32 pattern over 32 lanes takes 32 passes.
- R4: Lanes that address the same word share one access and add no passes. When all 32 lanes read one word, the request takes one pass and every lane returns that word.
- R5: When several lanes write the same word in one request, the data from the highest-numbered of those lanes is the value stored.
- R6: A read lane returns the value the word held before the request began, even if another lane of the same request writes that word.
- R7: After reset, `busy`, `done` and all read data are zero. `done` is a one-cycle pulse with `busy` low. `rd_data` stays valid and unchanged after `done` until the next request is accepted.
- R8: A `req_valid` raised while `busy` is high is ignored. Its writes never reach memory.
- R9: An inactive lane neither writes nor takes part in pass counting, and it returns zero read data. A write lane also returns zero read data. A request with no active lane completes in one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_active | input | 32 | Per-lane enable |
| req_write | input | 32 | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | 320 | Per-lane word address, lane n at bits [10n+9:10n] |
| req_wdata | input | 1024 | Per-lane write data, lane n at bits [32n+31:32n] |
| busy | output | 1 | High while passes remain |
| done | output | 1 | One-cycle pulse when the request completes |
| rd_data | output | 1024 | Per-lane read data, lane n at bits [32n+31:32n] |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a long replay. The bench starts a 32-pass stride write and then drives a conflicting write to a known word while `busy` is high. It reads that word back afterwards to show the stray write never landed. The other difficult case is a single bank that holds several distinct words, each named by many lanes. The bench groups lanes onto three words of one bank, which must give three passes and not thirty-two.

// File: rtl/scp_pkg.sv
// Package: shared default geometry for the banked scratchpad.
// Assumes power-of-two lane and bank counts.
package scp_pkg;
    localparam int SCP_LANES  = 32;
    localparam int SCP_BANKS  = 32;
    localparam int SCP_DATA_W = 32;
    localparam int SCP_ADDR_W = 10;
endpackage

// File: rtl/scp_bank_pick.sv
// Module: scp_bank_pick
// Chooses, for one bank, the word served in the current pass: the word of
// the lowest-numbered pending lane that maps to this bank. Every pending
// lane naming that same word is granted together. The write data comes
// from the highest-numbered granted writer.
// Assumes the bank index is the low BANK_W bits of the word address.
module scp_bank_pick #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int BANK_W  = 5,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES*DATA_W-1:0] lane_wdata,
    output logic [LANES-1:0]        grant,
    output logic                    bank_we,
    output logic [ADDR_W-BANK_W-1:0] bank_row,
    output logic [DATA_W-1:0]       bank_wdata
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_ID[BANK_W-1:0];

    logic [LANES-1:0]  hit;
    logic [ADDR_W-1:0] lead_addr;
    logic              found;

    // Purpose: mark pending lanes whose address falls in this bank.
    always_comb begin
        for (int l = 0; l < LANES; l++)
            hit[l] = pend[l] && (lane_addr[l*ADDR_W +: BANK_W] == MY_BANK);
    end

    // Purpose: take the address of the lowest-numbered hitting lane as leader.
    always_comb begin
        found     = 1'b0;
        lead_addr = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && hit[l]) begin
                found     = 1'b1;
                lead_addr = lane_addr[l*ADDR_W +: ADDR_W];
            end
        end
    end

    // Purpose: grant same-word lanes and merge their writes, last writer wins.
    always_comb begin
        bank_we    = 1'b0;
        bank_wdata = '0;
        for (int l = 0; l < LANES; l++) begin
            grant[l] = found && hit[l] &&
                       (lane_addr[l*ADDR_W +: ADDR_W] == lead_addr);
            if (grant[l] && lane_wr[l]) begin
                bank_we    = 1'b1;
                bank_wdata = lane_wdata[l*DATA_W +: DATA_W];
            end
        end
    end

    assign bank_row = lead_addr[ADDR_W-1:BANK_W];
endmodule

// File: rtl/scp_bank_store.sv
// Module: scp_bank_store
// One bank of word storage. It has a combinational read of the addressed
// row and a write on the clock edge, so a read and a write to one row in
// the same cycle return the old value.
// Assumes contents are undefined until written. There is no reset on storage.
module scp_bank_store #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] cells [ROWS];

    // Purpose: store the merged write word of this pass.
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[row] <= wdata;
    end

    assign rdata = cells[row];
endmodule

// File: rtl/scp_pass_ctrl.sv
// Module: scp_pass_ctrl
// Tracks which lanes still await service. It takes a request when idle and
// removes served lanes after each pass. It drops busy and pulses done once
// no lane remains. A request with no active lane still spends one pass.
// Assumes served only flags lanes that are pending.
module scp_pass_ctrl #(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LANES-1:0] active_in,
    input  logic [LANES-1:0] served,
    output logic             accept,
    output logic [LANES-1:0] pend,
    output logic             busy,
    output logic             done
);
    logic [LANES-1:0] pend_left;

    assign accept    = start && !busy;
    assign pend_left = pend & ~served;

    // Purpose: load, drain and retire the pending lane set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                pend <= active_in;
                busy <= 1'b1;
            end else if (busy) begin
                pend <= pend_left;
                if (pend_left == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pend != '0) |=> ($countones(pend) < $past($countones(pend)))); // R3
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pend == '0)); // R9
endmodule

// File: rtl/banked_scratchpad.sv
// Module: banked_scratchpad
// Top of the banked scratchpad. It latches one lane request and runs one
// pass per cycle. In each pass every bank serves one distinct word, and
// lanes sharing that word are served together. Read data of all lanes is
// presented with done.
// Assumes the requester honours busy. A request raised while busy is dropped.
module banked_scratchpad #(
    parameter int LANES  = scp_pkg::SCP_LANES,
    parameter int BANKS  = scp_pkg::SCP_BANKS,
    parameter int DATA_W = scp_pkg::SCP_DATA_W,
    parameter int ADDR_W = scp_pkg::SCP_ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES-1:0]        req_write,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES*DATA_W-1:0] req_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [LANES*DATA_W-1:0] rd_data
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic                    accept;
    logic [LANES-1:0]        pend;
    logic [LANES-1:0]        served;
    logic [LANES-1:0]        lat_write;
    logic [LANES*ADDR_W-1:0] lat_addr;
    logic [LANES*DATA_W-1:0] lat_wdata;

    logic [LANES-1:0]  bank_grant [BANKS];
    logic              bank_we    [BANKS];
    logic [ROW_W-1:0]  bank_row   [BANKS];
    logic [DATA_W-1:0] bank_wd    [BANKS];
    logic [DATA_W-1:0] bank_rd    [BANKS];
    logic [DATA_W-1:0] lane_rd    [LANES];

    scp_pass_ctrl #(.LANES(LANES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .active_in (req_active),
        .served    (served),
        .accept    (accept),
        .pend      (pend),
        .busy      (busy),
        .done      (done)
    );

    // Purpose: capture the lane vectors of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        scp_bank_pick #(
            .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .BANK_W(BANK_W), .BANK_ID(b)
        ) pick_i (
            .pend       (pend),
            .lane_wr    (lat_write),
            .lane_addr  (lat_addr),
            .lane_wdata (lat_wdata),
            .grant      (bank_grant[b]),
            .bank_we    (bank_we[b]),
            .bank_row   (bank_row[b]),
            .bank_wdata (bank_wd[b])
        );

        scp_bank_store #(.DATA_W(DATA_W), .ROW_W(ROW_W)) store_i (
            .clk   (clk),
            .wr_en (bank_we[b]),
            .row   (bank_row[b]),
            .wdata (bank_wd[b]),
            .rdata (bank_rd[b])
        );
    end

    // Purpose: collect per-lane service flags from all banks.
    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++)
            served = served | bank_grant[b];
    end

    // Purpose: route each lane to the read port of its own bank.
    always_comb begin
        for (int l = 0; l < LANES; l++)
            lane_rd[l] = bank_rd[lat_addr[l*ADDR_W +: BANK_W]];
    end

    // Purpose: clear read results on accept, fill them as read lanes are served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (accept) begin
            rd_data <= '0;
        end else if (busy) begin
            for (int l = 0; l < LANES; l++)
                if (served[l] && !lat_write[l])
                    rd_data[l*DATA_W +: DATA_W] <= lane_rd[l];
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(lat_addr) && $stable(lat_wdata))); // R8
    AST_RD_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> $stable(rd_data)); // R7
endmodule

// File: tb/banked_scratchpad_tb_top.sv
// Directed bench for banked_scratchpad. It keeps an independent word model
// and an independent pass count, with one task per scenario.
module banked_scratchpad_tb_top;
    localparam int LN = 32;
    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LN-1:0] req_active = '0;
    logic [LN-1:0] req_write = '0;
    logic [LN*AW-1:0] req_addr = '0;
    logic [LN*DW-1:0] req_wdata = '0;
    logic busy, done;
    logic [LN*DW-1:0] rd_data;

    logic [AW-1:0] t_addr [LN];
    logic [DW-1:0] t_wd   [LN];
    logic          t_act  [LN];
    logic          t_wr   [LN];
    logic [DW-1:0] mm     [1024];

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    banked_scratchpad dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_active(req_active), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_addr[l] = '0; t_wd[l] = '0; t_act[l] = 1'b0; t_wr[l] = 1'b0;
        end
    endtask

    // Issue the lane set, count busy cycles, compare passes and read data.
    task automatic run_req(input string req, input bit intrude);
        int exp_pass;
        int cnt;
        logic [DW-1:0] exp_rd [LN];
        exp_pass = 0;
        for (int b = 0; b < 32; b++) begin
            cnt = 0;
            for (int l = 0; l < LN; l++) begin
                bit dup;
                dup = 1'b0;
                for (int k = 0; k < l; k++)
                    if (t_act[k] && t_addr[k] == t_addr[l]) dup = 1'b1;
                if (t_act[l] && int'(t_addr[l] % 32) == b && !dup) cnt++;
            end
            if (cnt > exp_pass) exp_pass = cnt;
        end
        if (exp_pass == 0) exp_pass = 1;
        for (int l = 0; l < LN; l++)
            exp_rd[l] = (t_act[l] && !t_wr[l]) ? mm[t_addr[l]] : '0;
        for (int l = 0; l < LN; l++)
            if (t_act[l] && t_wr[l]) mm[t_addr[l]] = t_wd[l];

        @(negedge clk);
        for (int l = 0; l < LN; l++) begin
            req_active[l] = t_act[l];
            req_write[l]  = t_wr[l];
            req_addr[l*AW +: AW]  = t_addr[l];
            req_wdata[l*DW +: DW] = t_wd[l];
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!done && cnt < 100) begin
            if (busy) cnt++;
            if (intrude && cnt == 1) begin
                req_valid = 1'b1;
                req_active = '1;
                req_write = '1;
                for (int l = 0; l < LN; l++) begin
                    req_addr[l*AW +: AW]  = 10'd37;
                    req_wdata[l*DW +: DW] = 32'hDEAD_BEEF;
                end
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(cnt == exp_pass, req, "pass count", 64'(cnt), 64'(exp_pass));
        chk(done && !busy, req, "done with busy low", {busy, done}, 64'h1);
        for (int l = 0; l < LN; l++)
            chk(rd_data[l*DW +: DW] == exp_rd[l], req, $sformatf("lane %0d rd", l),
                64'(rd_data[l*DW +: DW]), 64'(exp_rd[l]));
    endtask

    task automatic read_back(input logic [AW-1:0] base, input int stride, input string req);
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_addr[l] = AW'(int'(base) + l * stride);
        end
        run_req(req, 1'b0);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R7", "reset busy/done", {busy, done}, 64'h0);
        chk(rd_data == '0, "R7", "reset rd_data", 64'(rd_data[63:0]), 64'h0);
    endtask

    task automatic t_unit_stride();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_addr[l] = AW'(l);
            t_wd[l] = 32'hA000_0000 + DW'(l);
        end
        run_req("R2", 1'b0);
        read_back(10'd0, 1, "R1");
    endtask

    task automatic t_stride32();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_addr[l] = AW'(l * 32 + 5);
            t_wd[l] = 32'h5000_0000 + DW'(l);
        end
        run_req("R3", 1'b0);
        read_back(10'd5, 32, "R3");
    endtask

    task automatic t_broadcast();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_addr[l] = 10'd7;
        end
        run_req("R4", 1'b0);
    endtask

    task automatic t_multi_writer();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_addr[l] = 10'd100;
            t_wd[l] = 32'hC000_0000 + DW'(l);
        end
        run_req("R5", 1'b0);
        clear_lanes();
        t_act[3] = 1'b1; t_addr[3] = 10'd100;
        run_req("R5", 1'b0);
    endtask

    task automatic t_read_old();
        clear_lanes();
        t_act[0] = 1'b1; t_addr[0] = 10'd10;
        t_act[5] = 1'b1; t_wr[5] = 1'b1; t_addr[5] = 10'd10; t_wd[5] = 32'h1234_5678;
        run_req("R6", 1'b0);
        clear_lanes();
        t_act[9] = 1'b1; t_addr[9] = 10'd10;
        run_req("R6", 1'b0);
    endtask

    task automatic t_grouped_bank();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1;
            t_addr[l] = (l < 10) ? 10'd5 : (l < 20) ? 10'd37 : 10'd69;
        end
        run_req("R3", 1'b0);
    endtask

    task automatic t_ignore_busy();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_addr[l] = AW'(l * 32 + 6);
            t_wd[l] = 32'h6000_0000 + DW'(l);
        end
        run_req("R8", 1'b1);
        clear_lanes();
        t_act[0] = 1'b1; t_addr[0] = 10'd37;
        run_req("R8", 1'b0);
    endtask

    task automatic t_inactive();
        clear_lanes();
        for (int l = 0; l < LN; l++) begin
            t_act[l] = (l % 2 == 0); t_wr[l] = 1'b1; t_addr[l] = AW'(l);
            t_wd[l] = 32'hBBBB_0000 + DW'(l);
        end
        run_req("R9", 1'b0);
        read_back(10'd0, 1, "R9");
        clear_lanes();
        run_req("R9", 1'b0);
    endtask

    task automatic t_hold_after_done();
        logic [LN*DW-1:0] snap;
        read_back(10'd0, 1, "R7");
        snap = rd_data;
        @(negedge clk);
        chk(!done, "R7", "done one cycle", 64'(done), 64'h0);
        repeat (3) @(negedge clk);
        chk(rd_data == snap, "R7", "rd held", 64'(rd_data[63:0]), 64'(snap[63:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unit_stride();
        t_stride32();
        t_broadcast();
        t_multi_writer();
        t_read_old();
        t_grouped_bank();
        t_ignore_busy();
        t_inactive();
        t_hold_after_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule